// File: doc/BRIEF.md
# SDRAM Command Legality Tracker

This block is a passive checker for an SDRAM command bus. Each clock it samples the active-low chip select, row strobe, column strobe and write enable, together with address bit 10 and the clock enable. It decodes the command, judges it against the device state it is tracking, and moves that state forward. The states are idle, row active, write recovery, write recovery ahead of auto precharge, precharging, refreshing, mode-register access, power down and self refresh.

The timed states (both write recovery states, precharging, refreshing and mode-register access) are held for a minimum number of cycles, each set by its own parameter. A command that is not allowed in the present state raises a one-cycle flag with a code that names the state it broke. The tracked state is left as it was. The block is meant to sit beside a memory controller in simulation or on silicon as a protocol monitor. It drives nothing back onto the bus.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset `state_o` is idle (0), `illegal_o` is 0 and `viol_code_o` is 0. State codes are: idle 0, active 1, write recovery 2, write recovery with auto precharge 3, precharging 4, refreshing 5, mode access 6, power down 7, self refresh 8.
- R2: With chip select low, the strobe pattern {ras_n,cas_n,we_n} is decoded as 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 001 refresh, 000 mode set. With chip select high the command is a deselect. In idle, activate goes to active, refresh goes to refreshing and mode set goes to mode access. Read and write are illegal. Precharge, deselect, no-op and burst stop leave the state as it is.
- R3: In active, a write goes to write recovery (a10=0) or to write recovery with auto precharge (a10=1). A read stays in active (a10=0) or goes to precharging (a10=1). Precharge goes to precharging. Activate, refresh and mode set are illegal.
- R4: Write recovery returns to active T_DPL cycles after entry when only deselect, no-op or burst stop are seen.
- R5: In write recovery, a new read or write is accepted and handled as in active, and a new write restarts the T_DPL count. Activate, precharge, refresh and mode set are illegal.
- R6: Write recovery with auto precharge moves to precharging T_DPL cycles after entry. Every command other than deselect, no-op and burst stop is illegal there.
- R7: Refreshing returns to idle T_RC cycles after entry. Every command other than deselect, no-op and burst stop is illegal there.
- R8: Mode access returns to idle T_RSC cycles after entry. Only deselect and no-op are allowed there; burst stop and all other commands are illegal.
- R9: Precharging returns to idle T_RP cycles after entry. Every command other than deselect, no-op and burst stop is illegal there.
- R10: An illegal command on edge k sets `illegal_o` for the cycle after k, with `viol_code_o` equal to the offending state code plus 1. The state does not change. When no command is illegal, `illegal_o` and `viol_code_o` are 0.
- R11: A timed state is measured from its entry edge. Neither no-op nor illegal commands restart the count. An expiry that falls on an illegal command is postponed to the next quiet cycle.
- R12: In idle with cke high on the previous edge, cke low enters self refresh if the command is refresh and power down otherwise. A low-power state returns to idle on the first edge with cke high. Commands sampled while the previous cke was low are ignored and never flagged, while pending expiries still proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| a10_i | input | 1 | Address bit 10 (auto precharge / all banks) |
| cke_i | input | 1 | Clock enable |
| state_o | output | 4 | Tracked state code |
| illegal_o | output | 1 | One-cycle illegal command flag |
| viol_code_o | output | 4 | Offending state code plus 1, or 0 |

## Verification
The bench targets expiry on the exact cycle. A design that reloads its counter on a no-op, or counts one cycle off, holds refreshing or precharging for too long or too short a time. It also targets an illegal command landing on the expiry cycle, where a wrong design leaves the state early or forgets to leave at all. Other cases are burst stop during mode access, which a design that reuses the generic no-op rule would accept, and a new write during write recovery, which must restart the count. It also covers the clock-enable boundary: a refresh with cke low must enter self refresh rather than power down, and commands after a low cke must never be flagged.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_ACTIVE  = 4'd1,
    ST_WREC    = 4'd2,
    ST_WREC_AP = 4'd3,
    ST_PRECHG  = 4'd4,
    ST_REFRESH = 4'd5,
    ST_MODE    = 4'd6,
    ST_PDOWN   = 4'd7,
    ST_SREF    = 4'd8
  } trk_state_e;

  typedef enum logic [3:0] {
    C_DESL, C_NOP, C_BST, C_READ, C_WRITE, C_ACT, C_PRE, C_REF, C_MRS
  } cmd_e;
endpackage

// File: rtl/sct_decode.sv
module sct_decode
  import sct_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n_i) cmd_o = C_DESL;
    else begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  cmd_o = C_NOP;
        3'b110:  cmd_o = C_BST;
        3'b101:  cmd_o = C_READ;
        3'b100:  cmd_o = C_WRITE;
        3'b011:  cmd_o = C_ACT;
        3'b010:  cmd_o = C_PRE;
        3'b001:  cmd_o = C_REF;
        default: cmd_o = C_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sct_timer.sv
module sct_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R11: an idle counter never wraps
  a_r11_hold_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/sct_rules.sv
module sct_rules
  import sct_pkg::*;
#(
  parameter int T_DPL = 2,
  parameter int T_RC  = 6,
  parameter int T_RSC = 2,
  parameter int T_RP  = 3,
  parameter int CNT_W = 3
) (
  input  trk_state_e       state_i,
  input  cmd_e             cmd_i,
  input  logic             a10_i,
  input  logic             cke_q_i,
  input  logic             cke_i,
  input  logic             cnt_zero_i,
  output trk_state_e       nxt_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             illegal_o
);
  localparam logic [CNT_W-1:0] LD_DPL = CNT_W'(T_DPL - 1);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] LD_RSC = CNT_W'(T_RSC - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);

  logic       quiet, quiet_mode;
  trk_state_e exp_nxt;
  logic       exp_load;

  assign quiet      = (cmd_i == C_DESL) || (cmd_i == C_NOP) || (cmd_i == C_BST);
  assign quiet_mode = (cmd_i == C_DESL) || (cmd_i == C_NOP);

  // expiry target of each timed state
  always_comb begin
    exp_nxt  = state_i;
    exp_load = 1'b0;
    if (cnt_zero_i) begin
      case (state_i)
        ST_WREC:    exp_nxt = ST_ACTIVE;
        ST_WREC_AP: begin exp_nxt = ST_PRECHG; exp_load = 1'b1; end
        ST_PRECHG, ST_REFRESH, ST_MODE: exp_nxt = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    nxt_o      = state_i;
    load_o     = 1'b0;
    load_val_o = '0;
    illegal_o  = 1'b0;
    if (state_i == ST_PDOWN || state_i == ST_SREF) begin
      if (cke_i) nxt_o = ST_IDLE;
    end else if (!cke_q_i) begin
      nxt_o      = exp_nxt;
      load_o     = exp_load;
      load_val_o = LD_RP;
    end else if (state_i == ST_IDLE && !cke_i) begin
      nxt_o = (cmd_i == C_REF) ? ST_SREF : ST_PDOWN;
    end else begin
      case (state_i)
        ST_IDLE: begin
          case (cmd_i)
            C_ACT: nxt_o = ST_ACTIVE;
            C_REF: begin nxt_o = ST_REFRESH; load_o = 1'b1; load_val_o = LD_RC; end
            C_MRS: begin nxt_o = ST_MODE; load_o = 1'b1; load_val_o = LD_RSC; end
            C_READ, C_WRITE: illegal_o = 1'b1;
            default: ;
          endcase
        end
        ST_ACTIVE, ST_WREC: begin
          case (cmd_i)
            C_READ: begin
              if (a10_i) begin nxt_o = ST_PRECHG; load_o = 1'b1; load_val_o = LD_RP; end
              else nxt_o = ST_ACTIVE;
            end
            C_WRITE: begin
              nxt_o      = a10_i ? ST_WREC_AP : ST_WREC;
              load_o     = 1'b1;
              load_val_o = LD_DPL;
            end
            C_PRE: begin
              if (state_i == ST_ACTIVE) begin
                nxt_o = ST_PRECHG; load_o = 1'b1; load_val_o = LD_RP;
              end else illegal_o = 1'b1;
            end
            C_ACT, C_REF, C_MRS: illegal_o = 1'b1;
            default: nxt_o = exp_nxt;
          endcase
        end
        ST_WREC_AP, ST_PRECHG, ST_REFRESH: begin
          if (quiet) begin
            nxt_o = exp_nxt; load_o = exp_load; load_val_o = LD_RP;
          end else illegal_o = 1'b1;
        end
        ST_MODE: begin
          if (quiet_mode) nxt_o = exp_nxt;
          else illegal_o = 1'b1;
        end
        default: nxt_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sct_pkg::*;
#(
  parameter int T_DPL = 2,
  parameter int T_RC  = 6,
  parameter int T_RSC = 2,
  parameter int T_RP  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic       ras_n_i,
  input  logic       cas_n_i,
  input  logic       we_n_i,
  input  logic       a10_i,
  input  logic       cke_i,
  output logic [3:0] state_o,
  output logic       illegal_o,
  output logic [3:0] viol_code_o
);
  localparam int T_A   = (T_DPL > T_RC) ? T_DPL : T_RC;
  localparam int T_B   = (T_RSC > T_RP) ? T_RSC : T_RP;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  cmd_e             cmd;
  trk_state_e       state_q, state_d;
  logic             cke_q, cnt_zero, load, ill_d, ill_q;
  logic [CNT_W-1:0] load_val;
  logic [3:0]       code_q;

  sct_decode i_decode (
    .cs_n_i (cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .cmd_o  (cmd)
  );

  sct_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(load_val),
    .zero_o(cnt_zero)
  );

  sct_rules #(
    .T_DPL(T_DPL), .T_RC(T_RC), .T_RSC(T_RSC), .T_RP(T_RP), .CNT_W(CNT_W)
  ) i_rules (
    .state_i(state_q), .cmd_i(cmd), .a10_i(a10_i), .cke_q_i(cke_q),
    .cke_i(cke_i), .cnt_zero_i(cnt_zero), .nxt_o(state_d), .load_o(load),
    .load_val_o(load_val), .illegal_o(ill_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cke_q   <= 1'b1;
      ill_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      cke_q   <= cke_i;
      ill_q   <= ill_d;
      code_q  <= ill_d ? 4'(state_q) + 4'd1 : 4'd0;
    end
  end

  assign state_o     = 4'(state_q);
  assign illegal_o   = ill_q;
  assign viol_code_o = code_q;

  // R10: an illegal command leaves the state untouched
  a_r10_hold_on_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_d |=> (state_q == $past(state_q)));
  // R10: code present exactly when flagged
  a_r10_code_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o == (viol_code_o != 4'd0));
  // R4: write recovery leaves only after the timer ran out
  a_r4_wrec_exit_timed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WREC && state_d == ST_ACTIVE && cmd != C_READ) |-> cnt_zero);
  // R7: refresh leaves only after the timer ran out
  a_r7_refresh_exit_timed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REFRESH && state_d != ST_REFRESH) |-> cnt_zero);
  // R12: self refresh is entered from idle only with cke low
  a_r12_sref_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && state_d == ST_SREF) |-> !cke_i);
  // R12: low-power exit requires cke high
  a_r12_lp_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_PDOWN || state_q == ST_SREF) && state_d == ST_IDLE) |-> cke_i);
endmodule

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  localparam int T_DPL = 2, T_RC = 6, T_RSC = 2, T_RP = 3;
  localparam logic [3:0] K_DESL = 4'b1111, K_NOP = 4'b0111, K_BST = 4'b0110,
    K_RD = 4'b0101, K_WR = 4'b0100, K_ACT = 4'b0011, K_PRE = 4'b0010,
    K_REF = 4'b0001, K_MRS = 4'b0000;
  localparam int S_IDLE = 0, S_ACT = 1, S_WREC = 2, S_WRAP = 3, S_PRE = 4,
    S_REF = 5, S_MODE = 6, S_PD = 7, S_SR = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0, cke = 1'b1;
  logic [3:0] state_o, viol_code_o;
  logic illegal_o;
  int errors = 0, checks = 0;
  bit done = 0;
  int m_st = 0, m_left = 0, m_code = 0;
  bit m_ckeq = 1, m_ill = 0;

  always #5 clk = ~clk;

  sdram_cmd_tracker #(.T_DPL(T_DPL), .T_RC(T_RC), .T_RSC(T_RSC), .T_RP(T_RP)) i_sdram_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .a10_i(a10), .cke_i(cke), .state_o(state_o),
    .illegal_o(illegal_o), .viol_code_o(viol_code_o));

  function automatic string tag_of(int st);
    case (st)
      S_IDLE: return "R2";
      S_ACT:  return "R3";
      S_WREC: return "R5";
      S_WRAP: return "R6";
      S_PRE:  return "R9";
      S_REF:  return "R7";
      S_MODE: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic cmp(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference of the tracker, derived from the requirements
  task automatic model_edge(logic [3:0] c_in, logic a, logic ck);
    logic [3:0] c;
    int nst, ld;
    bit quiet, qmode, ill;
    c = c_in; nst = m_st; ld = -1; ill = 0;
    if (!m_ckeq) c = K_NOP;
    quiet = c[3] || c[2:0] == 3'b111 || c[2:0] == 3'b110;
    qmode = c[3] || c[2:0] == 3'b111;
    if (m_st == S_PD || m_st == S_SR) begin
      if (ck) nst = S_IDLE;
    end else if (m_ckeq && m_st == S_IDLE && !ck) begin
      nst = (c == K_REF) ? S_SR : S_PD;
    end else begin
      case (m_st)
        S_IDLE: begin
          if (c == K_ACT) nst = S_ACT;
          else if (c == K_REF) begin nst = S_REF; ld = T_RC; end
          else if (c == K_MRS) begin nst = S_MODE; ld = T_RSC; end
          else if (c == K_RD || c == K_WR) ill = 1;
        end
        S_ACT, S_WREC: begin
          if (c == K_RD) begin
            if (a) begin nst = S_PRE; ld = T_RP; end else nst = S_ACT;
          end else if (c == K_WR) begin nst = a ? S_WRAP : S_WREC; ld = T_DPL; end
          else if (c == K_PRE && m_st == S_ACT) begin nst = S_PRE; ld = T_RP; end
          else if (!quiet) ill = 1;
          else if (m_st == S_WREC && m_left == 0) nst = S_ACT;
        end
        S_WRAP: begin
          if (!quiet) ill = 1;
          else if (m_left == 0) begin nst = S_PRE; ld = T_RP; end
        end
        S_PRE, S_REF: begin
          if (!quiet) ill = 1;
          else if (m_left == 0) nst = S_IDLE;
        end
        S_MODE: begin
          if (!qmode) ill = 1;
          else if (m_left == 0) nst = S_IDLE;
        end
        default: ;
      endcase
    end
    m_code = ill ? m_st + 1 : 0;
    m_ill = ill;
    m_st = nst;
    if (ld > 0) m_left = ld - 1;
    else if (m_left > 0) m_left--;
    m_ckeq = ck;
  endtask

  task automatic step(logic [3:0] c, logic a, logic ck, string tag);
    string t;
    {cs_n, ras_n, cas_n, we_n} = c; a10 = a; cke = ck;
    t = (tag == "") ? tag_of(m_st) : tag;
    @(posedge clk);
    model_edge(c, a, ck);
    @(negedge clk);
    if (m_ill) t = {t, "/R10"};
    cmp(t, state_o, m_st, "state");
    cmp(t, illegal_o, m_ill, "illegal");
    cmp(t, viol_code_o, m_code, "code");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    cmp("R1", state_o, 0, "reset state");
    cmp("R1", illegal_o, 0, "reset flag");
    cmp("R1", viol_code_o, 0, "reset code");
    // R2 idle decode and illegal read
    step(K_RD, 0, 1, "R2"); step(K_PRE, 1, 1, "R2"); step(K_BST, 0, 1, "R2");
    // R7 / R11: refresh timing with illegal command mid-way
    step(K_REF, 0, 1, "R7"); step(K_NOP, 0, 1, "R7"); step(K_ACT, 0, 1, "R11");
    for (int i = 0; i < T_RC; i++) step(K_DESL, 0, 1, "R7");
    // R11: illegal on the expiry cycle postpones exit
    step(K_MRS, 0, 1, "R8"); step(K_NOP, 0, 1, "R8"); step(K_BST, 0, 1, "R8");
    step(K_NOP, 0, 1, "R11"); step(K_NOP, 0, 1, "R8");
    // R3 / R4 / R5: write recovery and restart by a new write
    step(K_ACT, 0, 1, "R3"); step(K_REF, 0, 1, "R3"); step(K_WR, 0, 1, "R3");
    step(K_NOP, 0, 1, "R4"); step(K_WR, 0, 1, "R5"); step(K_PRE, 0, 1, "R5");
    step(K_NOP, 0, 1, "R4"); step(K_NOP, 0, 1, "R4");
    // R6 / R9: auto precharge path
    step(K_WR, 1, 1, "R6"); step(K_RD, 0, 1, "R6"); step(K_BST, 0, 1, "R6");
    for (int i = 0; i < T_RP + 1; i++) step(K_NOP, 0, 1, "R9");
    // R12: self refresh and power down
    step(K_REF, 0, 0, "R12"); step(K_ACT, 0, 0, "R12"); step(K_NOP, 0, 1, "R12");
    step(K_RD, 0, 0, "R12"); step(K_WR, 0, 1, "R12"); step(K_NOP, 0, 1, "R12");
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [3:0] c;
      r = $urandom_range(0, 15);
      case (r)
        6: c = K_DESL; 7: c = K_BST; 8: c = K_RD; 9: c = K_WR; 10: c = K_ACT;
        11: c = K_PRE; 12: c = K_REF; 13: c = K_MRS; default: c = K_NOP;
      endcase
      step(c, 1'($urandom_range(0, 1)), ($urandom_range(0, 19) != 0), "");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule